// File: doc/BRIEF.md
# Memory-Card Socket Status-Change Interrupt Unit

This block watches one memory-card socket and turns changes in its status lines into an interrupt request. It takes the two active-low card-detect lines, the ready line, the two battery-voltage-detect lines and a socket power-good level. Each input passes through a two-flop synchronizer. Qualified transitions are latched as sticky change flags. The flags are masked with per-event enables, and their OR drives a registered interrupt output. A 4-bit steering code beside the interrupt names the system interrupt line that software has chosen.

A control bit selects how the battery lines are read. For a memory card, the two lines report warning and dead conditions. For an I/O card, the first line is the card's active-low status-change signal, and it is reported through the battery-dead flag as a level. When a second control bit is set, removing the card produces a single-cycle configuration-reset pulse for the slot's configuration registers. Software reaches everything through a small 8-bit indexed read/write port. Reading the change register returns its flags and clears them.

Top module: `card_stat_irq`

## Requirements
- R1: After synchronous reset every register reads zero, `irq_o` and `cfg_rst_o` are low, and `irq_line_o` is zero. For the first SYNC_STAGES+1 cycles after reset, no change event is recorded.
- R2: Index 0 is a read-only live status register. Bit 0 is the first battery line (`bvd_i[0]`), bit 1 is the second (`bvd_i[1]`), bit 2 is ready, and bit 3 is power-good. Bits 7:4 read zero, and writes to this index change nothing.
- R3: Index 2 is the change register. Bit 3 is card-detect change, bit 2 is ready change, bit 1 is battery warning and bit 0 is battery dead. Bits 7:4 read zero. The flags stay set until the register is read, and the read clears them. Writes to this index change nothing.
- R4: The card counts as present only while both `cd_n_i` bits are low. Either edge of presence sets change bit 3. A card-detect change that leaves presence unchanged sets nothing.
- R5: A rising edge of ready sets change bit 2. A falling edge does not.
- R6: In memory-card mode, bit 1 is set on entry into the condition (`bvd_i[0]`=1 and `bvd_i[1]`=0). Bit 0 is set on entry into `bvd_i[0]`=0, so it does not set again after a read while that level persists.
- R7: In I/O-card mode, bit 0 is set in every cycle that `bvd_i[0]` is low, so it sets again after a read. Bit 1 is never set.
- R8: Index 1 is the control register. Bit 0 selects the card type (1 = I/O card) and bit 1 enables the configuration reset. Bits 7:2 read zero.
- R9: Index 3 is the interrupt configuration register. Bits 7:4 hold the steering code, which appears on `irq_line_o`. Bits 3:0 enable change bits 3:0 one for one.
- R10: `irq_o` is high exactly when some change bit is set and its enable is set. It follows the change register by one cycle.
- R11: When the configuration-reset enable is set and the card stops being present, `cfg_rst_o` is high for exactly one cycle. It never pulses while the enable is clear.
- R12: Indices 4 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cd_n_i | input | 2 | Card-detect lines, active low |
| rdy_i | input | 1 | Card ready (high) / busy (low) |
| bvd_i | input | 2 | Battery-voltage-detect lines; bit 0 is also the I/O-card status-change line |
| pwr_good_i | input | 1 | Socket power-on level |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_idx_i | input | IDX_W | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data, held until the next read |
| irq_o | output | 1 | Status-change interrupt request |
| irq_line_o | output | 4 | Steering code for the interrupt line |
| cfg_rst_o | output | 1 | One-cycle configuration-reset pulse |

## Verification
Directed sequences insert and remove the card, including half-removal where only one detect line rises. These show the difference between presence edges and raw line toggles, and between removal with and without the reset enable. The ready line is toggled in both directions, and the battery lines are walked through good, warning and dead in both card modes. The repeated read of a persisting dead level separates the edge-latched memory behaviour from the level-latched I/O behaviour. A random phase then applies arbitrary input sets, mode changes and enable masks. After each one it compares the change register, the interrupt and the count of reset pulses against a bench model, which exposes wrong masking, lost or spurious events and clear-on-read errors.

// File: rtl/csirq_pkg.sv
package csirq_pkg;
  localparam int DW  = 8;
  localparam int NEV = 4;

  localparam int EV_DEAD = 0;
  localparam int EV_WARN = 1;
  localparam int EV_RDY  = 2;
  localparam int EV_CD   = 3;

  typedef enum logic [1:0] {
    IX_STAT = 2'd0,
    IX_CTRL = 2'd1,
    IX_CHG  = 2'd2,
    IX_ICFG = 2'd3
  } reg_ix_e;

  typedef struct packed {
    logic [1:0] cd_n;
    logic       pwr;
    logic       rdy;
    logic       bvd2;
    logic       bvd1;
  } card_in_t;

  localparam int CIN_W = $bits(card_in_t);
endpackage

// File: rtl/csirq_sync.sv
module csirq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/csirq_evdet.sv
module csirq_evdet
  import csirq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  card_in_t       cur_i,
  input  logic           io_mode_i,
  output logic [NEV-1:0] evt_o,
  output logic           lost_o
);
  localparam int ARM_N = STAGES + 1;
  localparam int CW    = $clog2(ARM_N + 1);

  card_in_t      prv;
  logic [CW-1:0] arm_cnt;
  logic          armed;
  logic          pres_c, pres_p, warn_c, warn_p;

  assign armed = (arm_cnt == CW'(ARM_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt <= '0;
      prv     <= '0;
    end else begin
      prv <= cur_i;
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end
  end

  assign pres_c = (cur_i.cd_n == 2'b00);
  assign pres_p = (prv.cd_n == 2'b00);
  assign warn_c = !io_mode_i && cur_i.bvd1 && !cur_i.bvd2;
  assign warn_p = !io_mode_i && prv.bvd1 && !prv.bvd2;

  always_comb begin
    evt_o          = '0;
    evt_o[EV_CD]   = armed && (pres_c != pres_p);
    evt_o[EV_RDY]  = armed && cur_i.rdy && !prv.rdy;
    evt_o[EV_WARN] = armed && warn_c && !warn_p;
    if (io_mode_i) evt_o[EV_DEAD] = armed && !cur_i.bvd1;
    else           evt_o[EV_DEAD] = armed && !cur_i.bvd1 && prv.bvd1;
  end

  assign lost_o = armed && pres_p && !pres_c;
endmodule

// File: rtl/csirq_regs.sv
module csirq_regs
  import csirq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_idx_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic [NEV-1:0]   evt_i,
  input  logic [3:0]       live_i,
  output logic [NEV-1:0]   chg_o,
  output logic [NEV-1:0]   ena_o,
  output logic [3:0]       steer_o,
  output logic             io_mode_o,
  output logic             cfg_en_o,
  output logic [DW-1:0]    rdata_o
);
  logic       upper_zero;
  logic [1:0] lo_idx;
  logic       rd, wr;
  logic       hit_stat, hit_ctrl, hit_chg, hit_icfg;

  if (IDX_W > 2) begin : g_upper
    assign upper_zero = ~|bus_idx_i[IDX_W-1:2];
  end else begin : g_noupper
    assign upper_zero = 1'b1;
  end

  assign lo_idx   = bus_idx_i[1:0];
  assign rd       = bus_en_i && !bus_we_i;
  assign wr       = bus_en_i && bus_we_i;
  assign hit_stat = upper_zero && (lo_idx == IX_STAT);
  assign hit_ctrl = upper_zero && (lo_idx == IX_CTRL);
  assign hit_chg  = upper_zero && (lo_idx == IX_CHG);
  assign hit_icfg = upper_zero && (lo_idx == IX_ICFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_o     <= '0;
      ena_o     <= '0;
      steer_o   <= '0;
      io_mode_o <= 1'b0;
      cfg_en_o  <= 1'b0;
      rdata_o   <= '0;
    end else begin
      chg_o <= ((rd && hit_chg) ? '0 : chg_o) | evt_i;
      if (wr && hit_ctrl) begin
        io_mode_o <= bus_wdata_i[0];
        cfg_en_o  <= bus_wdata_i[1];
      end
      if (wr && hit_icfg) begin
        steer_o <= bus_wdata_i[7:4];
        ena_o   <= bus_wdata_i[3:0];
      end
      if (rd) begin
        rdata_o <= '0;
        if (hit_stat) rdata_o <= {4'h0, live_i};
        if (hit_ctrl) rdata_o <= {6'h00, cfg_en_o, io_mode_o};
        if (hit_chg)  rdata_o <= {4'h0, chg_o};
        if (hit_icfg) rdata_o <= {steer_o, ena_o};
      end
    end
  end
endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq
  import csirq_pkg::*;
#(
  parameter int IDX_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cd_n_i,
  input  logic             rdy_i,
  input  logic [1:0]       bvd_i,
  input  logic             pwr_good_i,
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_idx_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [7:0]       bus_rdata_o,
  output logic             irq_o,
  output logic [3:0]       irq_line_o,
  output logic             cfg_rst_o
);
  logic [CIN_W-1:0] raw_w, syn_w;
  card_in_t         cin_w;
  logic [NEV-1:0]   evt_w, chg_w, ena_w;
  logic             lost_w, io_mode_w, cfg_en_w;
  logic [3:0]       steer_w;
  logic             irq_q, pulse_q;

  assign raw_w = {cd_n_i, pwr_good_i, rdy_i, bvd_i[1], bvd_i[0]};

  csirq_sync #(.W(CIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_w),
    .q_o (syn_w)
  );

  assign cin_w = card_in_t'(syn_w);

  csirq_evdet #(.STAGES(SYNC_STAGES)) u_evdet (
    .clk       (clk),
    .rst       (rst),
    .cur_i     (cin_w),
    .io_mode_i (io_mode_w),
    .evt_o     (evt_w),
    .lost_o    (lost_w)
  );

  csirq_regs #(.IDX_W(IDX_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_idx_i   (bus_idx_i),
    .bus_wdata_i (bus_wdata_i),
    .evt_i       (evt_w),
    .live_i      ({cin_w.pwr, cin_w.rdy, cin_w.bvd2, cin_w.bvd1}),
    .chg_o       (chg_w),
    .ena_o       (ena_w),
    .steer_o     (steer_w),
    .io_mode_o   (io_mode_w),
    .cfg_en_o    (cfg_en_w),
    .rdata_o     (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      irq_q   <= |(chg_w & ena_w);
      pulse_q <= lost_w && cfg_en_w;
    end
  end

  assign irq_o      = irq_q;
  assign cfg_rst_o  = pulse_q;
  assign irq_line_o = steer_w;
endmodule

// File: rtl/csirq_chk.sv
module csirq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_en_i,
  input logic             bus_we_i,
  input logic [IDX_W-1:0] bus_idx_i,
  input logic [7:0]       bus_rdata_o,
  input logic             irq_o,
  input logic             cfg_rst_o,
  input logic [3:0]       chg,
  input logic [3:0]       ena,
  input logic [3:0]       evt,
  input logic             cfg_en
);
  logic rd_chg;
  assign rd_chg = bus_en_i && !bus_we_i && (bus_idx_i == IDX_W'(2));

  a_r10_no_irq_when_masked: assert property (@(posedge clk) disable iff (rst)
    (ena == 4'h0) |=> !irq_o);

  a_r11_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cfg_rst_o |=> !cfg_rst_o);

  a_r11_pulse_needs_enable: assert property (@(posedge clk) disable iff (rst)
    cfg_rst_o |-> $past(cfg_en));

  a_r3_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd_chg && evt == 4'h0) |=> (chg == 4'h0));

  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_chg |=> ((chg & $past(chg)) == $past(chg)));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_chg |=> (bus_rdata_o[7:4] == 4'h0));
endmodule

bind card_stat_irq csirq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_idx_i   (bus_idx_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .cfg_rst_o   (cfg_rst_o),
  .chg         (chg_w),
  .ena         (ena_w),
  .evt         (evt_w),
  .cfg_en      (cfg_en_w)
);

// File: tb/card_stat_irq_tb.sv
module card_stat_irq_tb;
  localparam int IDX_W = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cd_n = 2'b11;
  logic       rdy = 1'b1;
  logic [1:0] bvd = 2'b11;
  logic       pwr = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [IDX_W-1:0] bus_idx = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [3:0] irq_line;
  logic       cfg_rst;

  int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;

  logic [3:0] m_chg = '0, m_ena = '0, m_steer = '0;
  logic       m_io = 1'b0, m_cfgen = 1'b0;

  always #2 clk = ~clk;

  card_stat_irq #(.IDX_W(IDX_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cd_n_i(cd_n), .rdy_i(rdy), .bvd_i(bvd),
    .pwr_good_i(pwr), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_idx_i(bus_idx), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .irq_line_o(irq_line), .cfg_rst_o(cfg_rst)
  );

  always @(posedge clk) if (!rst && cfg_rst) pulses <= pulses + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {4'h0, pwr, rdy, bvd[1], bvd[0]};
  endfunction

  function automatic logic exp_irq();
    return |(m_chg & m_ena);
  endfunction

  task automatic io_level();
    if (m_io && !bvd[0]) m_chg[0] = 1'b1;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_idx = IDX_W'(idx); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (idx == 1) begin m_io = d[0]; m_cfgen = d[1]; io_level(); end
    if (idx == 3) begin m_steer = d[7:4]; m_ena = d[3:0]; end
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_idx = IDX_W'(idx);
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
    if (idx == 2) begin m_chg = '0; io_level(); end
    repeat (2) @(negedge clk);
  endtask

  task automatic apply(input logic [1:0] ncd, input logic nrdy, input logic [1:0] nbvd, input logic npwr);
    logic po, pn, wo, wn;
    po = (cd_n == 2'b00); pn = (ncd == 2'b00);
    if (po != pn) m_chg[3] = 1'b1;
    if (po && !pn && m_cfgen) exp_pulses++;
    if (nrdy && !rdy) m_chg[2] = 1'b1;
    if (!m_io) begin
      wo = bvd[0] && !bvd[1]; wn = nbvd[0] && !nbvd[1];
      if (wn && !wo) m_chg[1] = 1'b1;
      if (!nbvd[0] && bvd[0]) m_chg[0] = 1'b1;
    end
    @(negedge clk);
    cd_n = ncd; rdy = nrdy; bvd = nbvd; pwr = npwr;
    io_level();
    repeat (7) @(negedge clk);
  endtask

  task automatic chk_chg(input string tag);
    logic [7:0] d, e;
    e = {4'h0, m_chg};
    rd(2, d);
    check(d == e, tag, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    // R1: reset state
    check(irq == 1'b0 && cfg_rst == 1'b0 && irq_line == 4'h0, "R1 outputs", {irq, cfg_rst, irq_line}, 0);
    for (int i = 1; i < 4; i++) begin
      rd(i, d); check(d == 8'h00, "R1 reg zero", d, 0);
    end
    rd(0, d); check(d == exp_stat(), "R2 status", d, exp_stat());
    for (int i = 4; i < 8; i++) begin
      wr(i, 8'hFF); rd(i, d); check(d == 8'h00, "R12 unused index", d, 0);
    end
    wr(0, 8'hFF); rd(0, d); check(d == exp_stat(), "R2 read only", d, exp_stat());
    wr(2, 8'hFF); rd(2, d); check(d == 8'h00, "R3 write ignored", d, 0);
    wr(1, 8'hFF); rd(1, d); check(d == 8'h03, "R8 control", d, 3);
    wr(1, 8'h02);
    wr(3, 8'hA5); rd(3, d); check(d == 8'hA5, "R9 icfg", d, 8'hA5);
    check(irq_line == 4'hA, "R9 steering", irq_line, 4'hA);
    // R4 insertion, masked
    apply(2'b00, 1'b1, 2'b11, 1'b1);
    check(irq == 1'b0, "R10 masked cd", irq, 0);
    chk_chg("R4 insert");
    chk_chg("R3 cleared");
    // R11 removal with enable, R10 enabled irq
    wr(3, 8'hAF);
    apply(2'b01, 1'b1, 2'b11, 1'b1);
    check(irq == 1'b1, "R10 irq set", irq, 1);
    check(pulses == 1, "R11 one pulse", pulses, 1);
    chk_chg("R4 half removal");
    check(irq == 1'b0, "R10 irq clear", irq, 0);
    apply(2'b00, 1'b1, 2'b11, 1'b1);
    wr(1, 8'h00);
    apply(2'b11, 1'b1, 2'b11, 1'b1);
    check(pulses == 1, "R11 no pulse disabled", pulses, 1);
    chk_chg("R4 removal");
    apply(2'b10, 1'b1, 2'b11, 1'b1);
    chk_chg("R4 no presence change");
    apply(2'b00, 1'b1, 2'b11, 1'b1);
    chk_chg("R4 reinsert");
    // R5
    apply(2'b00, 1'b0, 2'b11, 1'b1);
    chk_chg("R5 falling ignored");
    apply(2'b00, 1'b1, 2'b11, 1'b1);
    chk_chg("R5 rising");
    // R6 memory battery
    apply(2'b00, 1'b1, 2'b01, 1'b1);
    chk_chg("R6 warning");
    apply(2'b00, 1'b1, 2'b00, 1'b1);
    chk_chg("R6 dead");
    chk_chg("R6 dead edge only");
    rd(0, d); check(d == exp_stat(), "R2 status live", d, exp_stat());
    // R7 I/O mode
    wr(1, 8'h01);
    chk_chg("R7 level");
    chk_chg("R7 level again");
    apply(2'b00, 1'b1, 2'b01, 1'b1);
    chk_chg("R7 no warning");
    // random phase
    for (int it = 0; it < 80; it++) begin
      logic [31:0] r;
      r = $urandom;
      if (it % 10 == 0) wr(1, {6'h0, r[9], r[8]});
      if (it % 7 == 0) wr(3, r[23:16]);
      apply(r[1:0], r[2], r[4:3], r[5]);
      check(irq == exp_irq(), "R10 random irq", irq, exp_irq());
      check(irq_line == m_steer, "R9 random steer", irq_line, m_steer);
      if (r[6]) chk_chg("R3 random chg");
      check(pulses == exp_pulses, "R11 random pulses", pulses, exp_pulses);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
  end
endmodule